// File: doc/BRIEF.md
# Configuration memory readout sequencer

This block feeds a stored configuration bitstream to a downstream programmable device. The bitstream sits in an on-chip read-only array that is computed at elaboration and split into equal revision regions. A reset phase, held while the output-enable/reset pin is low, picks the region and the output mode. The active region comes either from two external select pins or from a fixed internal revision value. After release, the block walks the region one item per rising clock edge. It sends one bit per clock on bit 0 in serial mode, or one byte per clock on all eight lines in parallel mode.

The output is a stream with a valid flag, `data_vld`. Items are produced only while the chip enable is active (low), the output-enable/reset pin is high and the configuration-request pin is high. In parallel mode `busy` acts as an inverted ready: a byte is accepted and the next one presented only on an edge where `busy` is low. While `busy` is high the byte holds unchanged. In serial mode every valid bit is taken on the next edge and `busy` has no effect. When the last byte of the region has been consumed, the stream stops and the cascade-enable output goes low, so a following memory can carry on the bitstream.

Top module: `cfg_stream_seq`

## Requirements
- R1: `data_vld` is high only while `ce_n` is low, `oe_rst` is high, `cfg_req` is high and the region is not finished. Whenever `data_vld` is low, `data_out` is all zeros.
- R2: On each rising edge with `oe_rst` low, the read position returns to the first byte of the selected region, at bit index 0. On the first cycle after release, that byte (or its top bit) is presented.
- R3: Region r covers array addresses r*REV_BYTES to r*REV_BYTES+REV_BYTES-1 (REV_BYTES=16 by default). With `ext_sel` high, r is `rev_sel`. With `ext_sel` low, r is the parameter INT_REV (default 2).
- R4: In serial mode (`par_mode`=0), `data_out[0]` carries the current byte most significant bit first and `data_out[7:1]` is zero. Each rising edge with `data_vld` high moves to the next bit, and after bit 0 it moves to the next byte.
- R5: In parallel mode (`par_mode`=1), `data_out[7:0]` carries the whole current byte. Each rising edge with `data_vld` high and `busy` low moves to the next byte.
- R6: In parallel mode, an edge with `busy` high leaves the byte and position unchanged. In serial mode, `busy` is ignored.
- R7: After the last byte of the region is consumed, `data_vld` stays low and `cas_en_n` stays low until `oe_rst` is driven low. At all other times after reset, `cas_en_n` is high.
- R8: `rev_sel`, `ext_sel` and `par_mode` are sampled only on edges with `oe_rst` low. Changes while `oe_rst` is high have no effect on the stream.
- R9: The array byte at address a is ((a*29 + 0x5A) XOR (a >> 3)) modulo 256.
- R10: An edge with `ce_n` high or `cfg_req` low does not advance the position. The stream resumes from the same item when both return to their active levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock, rising-edge active |
| ce_n | input | 1 | Chip enable, active low |
| oe_rst | input | 1 | Output enable when high, synchronous reset of the sequence when low |
| cfg_req | input | 1 | Configuration request, must be high for output |
| busy | input | 1 | Parallel-mode back-pressure, high stalls the byte |
| rev_sel | input | 2 | External revision select |
| ext_sel | input | 1 | High: take the revision from rev_sel, low: use INT_REV |
| par_mode | input | 1 | 1 = parallel byte mode, 0 = serial bit mode |
| data_out | output | 8 | Output data, bit 0 only in serial mode, zero when not valid |
| data_vld | output | 1 | Output item valid (models the driven, non-high-impedance state) |
| cas_en_n | output | 1 | Cascade enable for a following memory, active low |

## Verification
The assertions take for granted that `oe_rst` is held low over at least one rising edge before any stream starts, so that the sampled mode and region are defined. They also take for granted that `rev_sel`, `ext_sel` and `par_mode` carry known values on those edges. The stimulus starts with `oe_rst` low from time zero and always enters a new stream through a reset phase of several cycles. It changes the select and mode pins in the middle of a stream only to show that they are ignored there. All inputs change on the falling edge, so every sampled value is stable at the rising edge.

// File: rtl/cfg_seq_pkg.sv
package cfg_seq_pkg;
  localparam int BYTE_W = 8;
  localparam int BIT_IDX_W = $clog2(BYTE_W);

  typedef logic [BYTE_W-1:0] cfg_byte_t;

  // R9: array content as a closed-form function of the address
  function automatic cfg_byte_t cfg_rom_byte(input int unsigned a);
    int unsigned v;
    v = (a * 29 + 32'h5A) ^ (a >> 3);
    return cfg_byte_t'(v);
  endfunction
endpackage

// File: rtl/cfg_rom.sv
module cfg_rom
  import cfg_seq_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int ADDR_W = 6
) (
  input  logic [ADDR_W-1:0] addr,
  output cfg_byte_t         rd_byte
);
  cfg_byte_t mem [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_word
    assign mem[i] = cfg_rom_byte(i);
  end

  assign rd_byte = mem[addr];
endmodule

// File: rtl/cfg_addr_ctr.sv
module cfg_addr_ctr
  import cfg_seq_pkg::*;
#(
  parameter int REV_W     = 2,
  parameter int REV_BYTES = 16,
  parameter int ADDR_W    = 6
) (
  input  logic                 clk,
  input  logic                 oe_rst,
  input  logic                 run,
  input  logic                 busy,
  input  logic [REV_W-1:0]     rev_in,
  input  logic                 par_in,
  output logic [ADDR_W-1:0]    addr_q,
  output logic [BIT_IDX_W-1:0] bit_q,
  output logic                 par_q,
  output logic                 done_q
);
  localparam logic [BIT_IDX_W-1:0] LAST_BIT = BIT_IDX_W'(BYTE_W - 1);

  logic [ADDR_W-1:0] base_d, base_q, last_q;
  logic              adv, byte_end;

  assign base_d   = ADDR_W'(rev_in) * ADDR_W'(REV_BYTES);
  assign last_q   = base_q + ADDR_W'(REV_BYTES - 1);
  assign adv      = run && !done_q && (!par_q || !busy);
  assign byte_end = par_q || (bit_q == LAST_BIT);

  always_ff @(posedge clk) begin
    if (!oe_rst) begin
      base_q <= base_d;
      addr_q <= base_d;
      par_q  <= par_in;
      bit_q  <= '0;
      done_q <= 1'b0;
    end else if (adv) begin
      if (byte_end) begin
        bit_q <= '0;
        if (addr_q == last_q) done_q <= 1'b1;
        else                  addr_q <= addr_q + 1'b1;
      end else begin
        bit_q <= bit_q + 1'b1;
      end
    end
  end

  a_r6_busy_hold: assert property (@(posedge clk) disable iff (!oe_rst)
    (par_q && busy) |=> ($stable(addr_q) && $stable(done_q)));

  a_r7_done_sticky: assert property (@(posedge clk) disable iff (!oe_rst)
    done_q |=> done_q);

  a_r3_in_region: assert property (@(posedge clk) disable iff (!oe_rst)
    $past(oe_rst) |-> (addr_q >= base_q && addr_q <= last_q));

  a_r4_bit_before_byte: assert property (@(posedge clk) disable iff (!oe_rst)
    (!par_q && bit_q != LAST_BIT) |=> $stable(addr_q));

  a_r8_sampled_once: assert property (@(posedge clk) disable iff (!oe_rst)
    $past(oe_rst) |-> ($stable(par_q) && $stable(base_q)));

  a_r10_pause_hold: assert property (@(posedge clk) disable iff (!oe_rst)
    !run |=> ($stable(addr_q) && $stable(bit_q)));
endmodule

// File: rtl/cfg_out_fmt.sv
module cfg_out_fmt
  import cfg_seq_pkg::*;
(
  input  cfg_byte_t            cur_byte,
  input  logic [BIT_IDX_W-1:0] bit_idx,
  input  logic                 par_q,
  input  logic                 active,
  output cfg_byte_t            data_out,
  output logic                 data_vld
);
  localparam logic [BIT_IDX_W-1:0] TOP_BIT = BIT_IDX_W'(BYTE_W - 1);

  logic ser_bit;

  assign ser_bit = cur_byte[TOP_BIT - bit_idx];

  always_comb begin
    data_out = '0;
    if (active) begin
      if (par_q) data_out = cur_byte;
      else       data_out[0] = ser_bit;
    end
  end

  assign data_vld = active;
endmodule

// File: rtl/cfg_stream_seq.sv
module cfg_stream_seq
  import cfg_seq_pkg::*;
#(
  parameter int REV_W     = 2,
  parameter int REV_BYTES = 16,
  parameter int INT_REV   = 2
) (
  input  logic             clk,
  input  logic             ce_n,
  input  logic             oe_rst,
  input  logic             cfg_req,
  input  logic             busy,
  input  logic [REV_W-1:0] rev_sel,
  input  logic             ext_sel,
  input  logic             par_mode,
  output logic [7:0]       data_out,
  output logic             data_vld,
  output logic             cas_en_n
);
  localparam int NUM_REV = 2 ** REV_W;
  localparam int DEPTH   = NUM_REV * REV_BYTES;
  localparam int ADDR_W  = $clog2(DEPTH);

  logic [REV_W-1:0]     rev_eff;
  logic                 run, active;
  logic [ADDR_W-1:0]    addr_q;
  logic [BIT_IDX_W-1:0] bit_q;
  logic                 par_q, done_q;
  cfg_byte_t            cur_byte;

  assign rev_eff = ext_sel ? rev_sel : REV_W'(INT_REV);
  assign run     = !ce_n && oe_rst && cfg_req;
  assign active  = run && !done_q;

  cfg_addr_ctr #(.REV_W(REV_W), .REV_BYTES(REV_BYTES), .ADDR_W(ADDR_W)) u_ctr (
    .clk    (clk),
    .oe_rst (oe_rst),
    .run    (run),
    .busy   (busy),
    .rev_in (rev_eff),
    .par_in (par_mode),
    .addr_q (addr_q),
    .bit_q  (bit_q),
    .par_q  (par_q),
    .done_q (done_q)
  );

  cfg_rom #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_rom (
    .addr    (addr_q),
    .rd_byte (cur_byte)
  );

  cfg_out_fmt u_fmt (
    .cur_byte (cur_byte),
    .bit_idx  (bit_q),
    .par_q    (par_q),
    .active   (active),
    .data_out (data_out),
    .data_vld (data_vld)
  );

  assign cas_en_n = !done_q;

  a_r7_handoff_quiet: assert property (@(posedge clk) disable iff (!oe_rst)
    $fell(cas_en_n) |-> !data_vld);

  a_r1_no_data_in_reset: assert property (@(posedge clk)
    !oe_rst |-> !data_vld);
endmodule

// File: tb/cfg_stream_seq_bench.sv
`timescale 1ns/1ps
module cfg_stream_seq_bench;
  logic       clk = 1'b0;
  logic       ce_n, oe_rst, cfg_req, busy, ext_sel, par_mode;
  logic [1:0] rev_sel;
  logic [7:0] data_out;
  logic       data_vld, cas_en_n;

  int    n_run = 0, n_fail = 0;
  bit    finished = 0;
  string tag = "R1";

  // behavioural reference state
  int m_addr, m_bit, m_rev;
  bit m_par, m_done, m_init = 0;

  always #2 clk = ~clk;

  cfg_stream_seq u_cfg_stream_seq (
    .clk(clk), .ce_n(ce_n), .oe_rst(oe_rst), .cfg_req(cfg_req), .busy(busy),
    .rev_sel(rev_sel), .ext_sel(ext_sel), .par_mode(par_mode),
    .data_out(data_out), .data_vld(data_vld), .cas_en_n(cas_en_n)
  );

  function automatic int exp_byte(int a);
    return ((a * 29 + 90) ^ (a / 8)) % 256;
  endfunction

  task automatic check(string t, logic [9:0] got, logic [9:0] want);
    n_run++;
    if (got !== want) begin
      n_fail++;
      $display("FAIL %s: got vld=%0b cas_n=%0b data=%02h, expected vld=%0b cas_n=%0b data=%02h",
               t, got[9], got[8], got[7:0], want[9], want[8], want[7:0]);
    end
  endtask

  // one clock: inputs set at negedge, outputs compared, model advanced at posedge
  task automatic cycle(bit ce, bit oe, bit req, bit bsy);
    bit         act;
    logic [7:0] wd;
    @(negedge clk);
    ce_n = ce; oe_rst = oe; cfg_req = req; busy = bsy;
    #1;
    if (m_init) begin
      act = !ce && oe && req && !m_done;
      wd  = 8'h00;
      if (act) wd = m_par ? 8'(exp_byte(m_addr)) : 8'((exp_byte(m_addr) >> (7 - m_bit)) & 1);
      check(tag, {data_vld, cas_en_n, data_out}, {act, !m_done, wd});
    end
    @(posedge clk);
    if (!oe) begin
      m_rev  = ext_sel ? int'(rev_sel) : 2;
      m_par  = par_mode;
      m_addr = m_rev * 16;
      m_bit  = 0;
      m_done = 0;
      m_init = 1;
    end else if (!ce && req && !m_done && (!m_par || !bsy)) begin
      if (m_par || m_bit == 7) begin
        m_bit = 0;
        if (m_addr == m_rev * 16 + 15) m_done = 1;
        else m_addr++;
      end else m_bit++;
    end
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: got no end, expected end of run");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    ce_n = 0; oe_rst = 0; cfg_req = 1; busy = 0;
    rev_sel = 2'd1; ext_sel = 1; par_mode = 0;

    // R1 / R2: reset phase, external revision 1, serial
    tag = "R1";
    for (int i = 0; i < 3; i++) cycle(0, 0, 1, 0);
    // R4 serial stream, R6 busy ignored, R8 mid-stream pin changes ignored
    for (int i = 0; i < 16 * 8 + 4; i++) begin
      tag = (i == 0) ? "R2" : (i >= 128) ? "R7" : (i % 3 == 0) ? "R6" : "R4";
      if (i == 20) begin rev_sel = 2'd3; par_mode = 1; ext_sel = 0; tag = "R8"; end
      cycle(0, 1, 1, (i % 3 == 0));
    end

    // R3: internal revision (INT_REV=2) with pins pointing elsewhere, parallel mode
    rev_sel = 2'd3; ext_sel = 0; par_mode = 1;
    tag = "R7";
    for (int i = 0; i < 2; i++) cycle(0, 0, 1, 0);
    for (int i = 0; i < 40; i++) begin
      bit c, r;
      c = (i >= 6 && i < 9);
      r = !(i >= 12 && i < 14);
      tag = (i == 0) ? "R3" : (c || !r) ? "R10" : (i % 4 == 1) ? "R6" : (i > 30) ? "R7" : "R5";
      if (i == 15) begin par_mode = 0; tag = "R8"; end
      cycle(c, 1, r, (i % 4 == 1));
    end

    // R9: external revision 0, parallel, full content read out
    rev_sel = 2'd0; ext_sel = 1; par_mode = 1;
    tag = "R1";
    for (int i = 0; i < 2; i++) cycle(0, 0, 1, 0);
    for (int i = 0; i < 18; i++) begin
      tag = "R9";
      cycle(0, 1, 1, 0);
    end
    tag = "R7";
    cycle(0, 0, 1, 0);
    cycle(0, 1, 1, 0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule